// File: doc/BRIEF.md
# Microwire EEPROM host controller

This block is the master side of a three-wire-plus-return serial link to a small Microwire EEPROM organised as 64 words of 16 bits. A local client posts one command at a time on a valid/ready handshake: a 3-bit operation code, a word address and, for writes, a data word. The controller then builds the serial frame and drives chip select, serial clock and data toward the memory. It samples the memory's data output and answers with a one-cycle done pulse that carries read data and a timeout flag.

The serial clock comes from the system clock. Each high phase lasts `SK_HI` system clocks and each low phase lasts `SK_LO`. Between frames, chip select stays low for `CS_GAP` clocks. After an operation that programs the array, the controller raises chip select again with the serial clock held low. It then watches the data line until the memory reports ready, or until `POLL_MAX` clocks pass.

The controller is built around one state machine with five states:
- `ST_GAP`: chip select low for the minimum interval. Out of reset the machine starts here.
- `ST_IDLE`: accepting a request.
- `ST_LOW`: clock low, data line updated.
- `ST_HIGH`: clock high; the data output is sampled at the end of this phase.
- `ST_POLL`: status watch.

Its transitions are:
- GAP to IDLE when the gap expires with no poll pending. If the gap followed a finished command, done is pulsed on this transition.
- GAP to POLL when the gap expires after a programming frame.
- IDLE to LOW when a request is accepted.
- LOW to HIGH when the low phase expires.
- HIGH to LOW when the high phase expires and bits remain.
- HIGH to GAP after the last bit.
- POLL to GAP on ready or on timeout.

Top module: `mw_host`

## Requirements
- R1: Each frame is sent most significant bit first, in this order: a start bit of 1, two opcode bits, `ADDR_W` address bits, then `DATA_W` data bits for write and write-all. Write uses opcode 01, so data written to an address reads back unchanged.
- R2: Request codes on `req_op` are 0 read, 1 write, 2 erase, 3 write enable, 4 write disable, 5 write all, 6 erase all, and 7 is treated as write disable. The device opcodes are 10 for read and 11 for erase. Control commands use opcode 00, and the two top address bits select the command: 11 enable, 00 disable, 01 write all, 10 erase all. The remaining address bits are sent as 0.
- R3: A read runs `3+ADDR_W+DATA_W` serial clocks. The leading dummy bit is discarded, and `rsp_rdata` holds D15..D0 when `rsp_done` pulses. `rsp_done` pulses `(3+ADDR_W+DATA_W)*(SK_HI+SK_LO)+CS_GAP` clocks after the accepting edge.
- R4: Chip select falls in the same cycle as the falling clock of the last frame bit, so no further rising clock edge occurs. Frames with data have `3+ADDR_W+DATA_W` rising edges; the others have `3+ADDR_W`.
- R5: Chip select stays low for at least `CS_GAP` clocks before every rise, including the first rise after reset. During reset, chip select is 0 and `req_ready` is 0. `req_ready` rises `CS_GAP` cycles after reset is released.
- R6: Every clock high phase lasts exactly `SK_HI` clocks. Every low phase inside a frame lasts at least `SK_LO` clocks. The data line changes only while the serial clock is low, and the serial clock is low whenever chip select is low.
- R7: After write, erase, write all or erase all, the controller raises chip select with no serial clock and waits for `mw_do`=1. It then drops chip select and, after the gap, pulses `rsp_done` with `rsp_timeout`=0.
- R8: If ready is not seen within `POLL_MAX` clocks of polling, the controller drops chip select and pulses `rsp_done` with `rsp_timeout`=1. For a 9-bit command this happens `(3+ADDR_W)*(SK_HI+SK_LO)+2*CS_GAP+POLL_MAX` clocks after the accepting edge.
- R9: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, `req_ready` is low on the next cycle, and each accepted request yields exactly one single-cycle `rsp_done`.
- R10: Read, enable and disable finish without polling. Enable and disable pulse `rsp_done` `(3+ADDR_W)*(SK_HI+SK_LO)+CS_GAP` clocks after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller idle, can take a request |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for write and write all |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with done after a read |
| rsp_timeout | output | 1 | Status poll timed out, valid with done |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data / status from the memory |

## Verification
The bench builds the controller with the default 6-bit address and 16-bit data, `SK_HI`=2, `SK_LO`=3, `CS_GAP`=4 and `POLL_MAX`=200. It attaches a behavioural memory model that stays busy for 40 clocks per programming operation and can be made permanently busy. The short clock phases and gap make an exact latency check on every read practical. With them, all 64 addresses can be written and read back with arithmetic patterns, and the whole-array and erase commands can each be followed by readback. The small poll limit brings the timeout path within a few hundred cycles.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_FILL  = 3'd5,
        OP_WIPE  = 3'd6
    } mw_op_e;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_POLL
    } mw_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_CTRL  = 2'b00;

    localparam logic [1:0] CTL_EN    = 2'b11;
    localparam logic [1:0] CTL_DIS   = 2'b00;
    localparam logic [1:0] CTL_FILL  = 2'b01;
    localparam logic [1:0] CTL_WIPE  = 2'b10;

endpackage

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 3 + ADDR_W + DATA_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [2:0]         op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [FRAME_W-1:0] bits,
    output logic [LEN_W-1:0]   len,
    output logic               prog
);
    localparam int CMD_W = 3 + ADDR_W;

    logic [1:0]        opc;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;

    always_comb begin
        opc  = OPC_CTRL;
        a    = addr;
        d    = '0;
        len  = LEN_W'(CMD_W);
        prog = 1'b0;
        unique case (mw_op_e'(op))
            OP_READ: begin
                opc = OPC_READ;
                len = LEN_W'(FRAME_W);
            end
            OP_WRITE: begin
                opc  = OPC_WRITE;
                d    = wdata;
                len  = LEN_W'(FRAME_W);
                prog = 1'b1;
            end
            OP_ERASE: begin
                opc  = OPC_ERASE;
                prog = 1'b1;
            end
            OP_WREN: a = {CTL_EN, {(ADDR_W-2){1'b0}}};
            OP_FILL: begin
                a    = {CTL_FILL, {(ADDR_W-2){1'b0}}};
                d    = wdata;
                len  = LEN_W'(FRAME_W);
                prog = 1'b1;
            end
            OP_WIPE: begin
                a    = {CTL_WIPE, {(ADDR_W-2){1'b0}}};
                prog = 1'b1;
            end
            default: a = {CTL_DIS, {(ADDR_W-2){1'b0}}};
        endcase
        bits = {1'b1, opc, a, d};
    end

endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (ld)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/mw_host.sv
module mw_host
    import mw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int SK_HI    = 4,
    parameter int SK_LO    = 4,
    parameter int CS_GAP   = 8,
    parameter int POLL_MAX = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int PH_MAX  = (SK_HI > SK_LO) ? SK_HI : SK_LO;
    localparam int T1_MAX  = (PH_MAX > CS_GAP) ? PH_MAX : CS_GAP;
    localparam int T_MAX   = (T1_MAX > POLL_MAX) ? T1_MAX : POLL_MAX;
    localparam int TMR_W   = $clog2(T_MAX + 1);

    mw_state_e state_q, state_d;

    logic               tmr_ld, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic [FRAME_W-1:0] f_bits;
    logic [LEN_W-1:0]   f_len;
    logic               f_prog;

    logic [FRAME_W-2:0] tx;
    logic [DATA_W-1:0]  rx;
    logic [LEN_W-1:0]   len_q, sent;
    logic               prog_q, poll_pend, done_pend;
    logic               last_bit;

    mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) i_frame (
        .op    (req_op),
        .addr  (req_addr),
        .wdata (req_wdata),
        .bits  (f_bits),
        .len   (f_len),
        .prog  (f_prog)
    );

    mw_timer #(.W(TMR_W), .RST_VAL(CS_GAP - 1)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (tmr_ld),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    assign last_bit  = (sent == len_q - 1'b1);
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_rdata = rx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_GAP;
        else
            state_q <= state_d;
    end

    // next state and phase timer reload
    always_comb begin
        state_d = state_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (state_q)
            ST_GAP: if (tmr_zero) begin
                if (poll_pend) begin
                    state_d = ST_POLL;
                    tmr_ld  = 1'b1;
                    tmr_val = TMR_W'(POLL_MAX - 1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: if (req_valid) begin
                state_d = ST_LOW;
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(SK_LO - 1);
            end
            ST_LOW: if (tmr_zero) begin
                state_d = ST_HIGH;
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(SK_HI - 1);
            end
            ST_HIGH: if (tmr_zero) begin
                tmr_ld = 1'b1;
                if (last_bit) begin
                    state_d = ST_GAP;
                    tmr_val = TMR_W'(CS_GAP - 1);
                end else begin
                    state_d = ST_LOW;
                    tmr_val = TMR_W'(SK_LO - 1);
                end
            end
            ST_POLL: if (mw_do || tmr_zero) begin
                state_d = ST_GAP;
                tmr_ld  = 1'b1;
                tmr_val = TMR_W'(CS_GAP - 1);
            end
            default: state_d = ST_GAP;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mw_cs       <= 1'b0;
            mw_sk       <= 1'b0;
            mw_di       <= 1'b0;
            tx          <= '0;
            rx          <= '0;
            len_q       <= '0;
            sent        <= '0;
            prog_q      <= 1'b0;
            poll_pend   <= 1'b0;
            done_pend   <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state_q)
                ST_GAP: if (tmr_zero) begin
                    if (poll_pend) begin
                        mw_cs     <= 1'b1;
                        poll_pend <= 1'b0;
                    end else if (done_pend) begin
                        rsp_done  <= 1'b1;
                        done_pend <= 1'b0;
                    end
                end
                ST_IDLE: if (req_valid) begin
                    tx          <= f_bits[FRAME_W-2:0];
                    mw_di       <= f_bits[FRAME_W-1];
                    len_q       <= f_len;
                    prog_q      <= f_prog;
                    sent        <= '0;
                    mw_cs       <= 1'b1;
                    rsp_timeout <= 1'b0;
                end
                ST_LOW: if (tmr_zero) mw_sk <= 1'b1;
                ST_HIGH: if (tmr_zero) begin
                    mw_sk <= 1'b0;
                    rx    <= {rx[DATA_W-2:0], mw_do};
                    sent  <= sent + 1'b1;
                    tx    <= {tx[FRAME_W-3:0], 1'b0};
                    if (last_bit) begin
                        mw_cs     <= 1'b0;
                        mw_di     <= 1'b0;
                        poll_pend <= prog_q;
                        done_pend <= !prog_q;
                    end else begin
                        mw_di <= tx[FRAME_W-2];
                    end
                end
                ST_POLL: if (mw_do || tmr_zero) begin
                    mw_cs       <= 1'b0;
                    done_pend   <= 1'b1;
                    rsp_timeout <= !mw_do;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
    parameter int SK_HI  = 4,
    parameter int SK_LO  = 4,
    parameter int CS_GAP = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_di
);
    localparam int M1   = (SK_HI > SK_LO) ? SK_HI : SK_LO;
    localparam int MX   = (M1 > CS_GAP) ? M1 : CS_GAP;
    localparam int CW   = $clog2(MX + 2);
    localparam logic [CW-1:0] CSAT = {CW{1'b1}};

    logic [CW-1:0] hi_run, lo_run, cs_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            cs_run <= '0;
        end else begin
            hi_run <= mw_sk ? ((hi_run == CSAT) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= (mw_cs && !mw_sk) ? ((lo_run == CSAT) ? lo_run : lo_run + 1'b1) : '0;
            cs_run <= !mw_cs ? ((cs_run == CSAT) ? cs_run : cs_run + 1'b1) : '0;
        end
    end

    p_sk_high_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_sk) |-> (hi_run >= CW'(SK_HI)));

    p_sk_low_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_sk) |-> (lo_run >= CW'(SK_LO)));

    p_di_when_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_di != $past(mw_di)) |-> !mw_sk);

    p_sk_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sk);

    p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_cs) |-> (cs_run >= CW'(CS_GAP)));

    p_cs_end_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_cs) |-> !mw_sk);

    p_accept_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind mw_host mw_host_chk #(.SK_HI(SK_HI), .SK_LO(SK_LO), .CS_GAP(CS_GAP)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mw_cs     (mw_cs),
    .mw_sk     (mw_sk),
    .mw_di     (mw_di)
);

// File: tb/test_mw_host.sv
module test_mw_host;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int SK_HI    = 2;
    localparam int SK_LO    = 3;
    localparam int CS_GAP   = 4;
    localparam int POLL_MAX = 200;
    localparam int BUSY     = 40;
    localparam int LONG     = 3 + ADDR_W + DATA_W;
    localparam int SHORT    = 3 + ADDR_W;
    localparam int PER      = SK_HI + SK_LO;

    logic clk, rst_n;
    logic req_valid, req_ready, rsp_done, rsp_timeout;
    logic [2:0] req_op;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rsp_rdata;
    logic mw_cs, mw_sk, mw_di, mw_do;

    mw_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SK_HI(SK_HI), .SK_LO(SK_LO),
              .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX)) i_mw_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural memory model
    logic [15:0] mem [64];
    int   busy, bitn, rises, exp_rises;
    int   hi_run, lo_run, cslo_run;
    bit   stuck, wen_m, status, rdm, do_bit;
    logic [24:0] sh;
    logic [15:0] outw;
    logic sk_p, cs_p, di_p;

    assign mw_do = mw_cs && (rdm ? do_bit : (status && busy == 0));

    task automatic start_prog();
        status = 1'b1;
        busy   = wen_m ? BUSY : 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 64; a++) mem[a] = 16'h0F00 ^ 16'(a);
            busy = 0; bitn = 0; rises = 0; hi_run = 0; lo_run = 0; cslo_run = 0;
            wen_m = 0; status = 0; rdm = 0; do_bit = 0; sh = '0; outw = '0;
            sk_p = 0; cs_p = 0; di_p = 0;
        end else begin
            if (busy > 0 && !stuck) busy--;
            // R6 clock shape and data stability
            if (mw_sk) hi_run++;
            else if (sk_p) begin
                chk(hi_run == SK_HI, "R6 high phase", hi_run, SK_HI);
                hi_run = 0;
            end
            if (mw_cs && !mw_sk) lo_run++;
            if (!mw_cs) lo_run = 0;
            if (mw_sk && !sk_p) begin
                chk(lo_run >= SK_LO, "R6 low phase", lo_run, SK_LO);
                lo_run = 0;
            end
            if (mw_di != di_p) chk(!mw_sk, "R6 data moved with clock high", 1, 0);
            if (!mw_cs && mw_sk) chk(0, "R6 clock with select low", 1, 0);
            // R5 select gap
            if (!mw_cs) cslo_run++;
            if (mw_cs && !cs_p) begin
                chk(cslo_run >= CS_GAP, "R5 select gap", cslo_run, CS_GAP);
                cslo_run = 0;
                rises = 0;
            end
            // serial rising edge
            if (mw_cs && mw_sk && !sk_p) begin
                rises++;
                if (rdm) begin
                    do_bit = outw[15];
                    outw   = {outw[14:0], 1'b0};
                end else begin
                    sh = {sh[23:0], mw_di};
                    bitn++;
                    if (bitn == 9 && sh[8] && sh[7:6] == 2'b10) begin
                        rdm    = 1'b1;
                        outw   = mem[sh[5:0]];
                        do_bit = 1'b0;
                    end
                end
            end
            // select falling: execute
            if (!mw_cs && cs_p) begin
                if (rises != 0) chk(rises == exp_rises, "R4 rising edge count", rises, exp_rises);
                if (bitn == 9 && !rdm && sh[8]) begin
                    if (sh[7:6] == 2'b00) begin
                        case (sh[5:4])
                            2'b11: wen_m = 1'b1;
                            2'b00: wen_m = 1'b0;
                            2'b10: begin
                                if (wen_m) for (int a = 0; a < 64; a++) mem[a] = 16'hFFFF;
                                start_prog();
                            end
                            default: ;
                        endcase
                    end else if (sh[7:6] == 2'b11) begin
                        if (wen_m) mem[sh[5:0]] = 16'hFFFF;
                        start_prog();
                    end
                end else if (bitn == 25 && sh[24]) begin
                    if (sh[23:22] == 2'b01) begin
                        if (wen_m) mem[sh[21:16]] = sh[15:0];
                        start_prog();
                    end else if (sh[23:22] == 2'b00 && sh[21:20] == 2'b01) begin
                        if (wen_m) for (int a = 0; a < 64; a++) mem[a] = sh[15:0];
                        start_prog();
                    end
                end else if (bitn == 0 && status && busy == 0) begin
                    status = 1'b0;
                end
                bitn = 0; sh = '0; rdm = 1'b0;
            end
            sk_p = mw_sk; cs_p = mw_cs; di_p = mw_di;
        end
    end

    task automatic run(input logic [2:0] op, input int a, input logic [15:0] d,
                       input int nr, output int lat);
        while (!req_ready) @(negedge clk);
        exp_rises = nr;
        req_op    = op;
        req_addr  = ADDR_W'(a);
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 1031) ^ 16'h5A3C);
    endfunction

    task automatic read_chk(input int a, input logic [15:0] exp, input string tag);
        int lat;
        run(3'd0, a, 16'h0, LONG, lat);
        chk(rsp_rdata == exp, tag, rsp_rdata, exp);
        chk(lat == LONG * PER + CS_GAP + 1, "R3 read latency", lat, LONG * PER + CS_GAP + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        int lat, n;
        stuck = 0; exp_rises = 0;
        req_valid = 0; req_op = '0; req_addr = '0; req_wdata = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(mw_cs == 0 && mw_sk == 0, "R5 select low in reset", mw_cs, 0);
        chk(req_ready == 0, "R5 not ready in reset", req_ready, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 0, "R5 not ready during first gap", req_ready, 0);
        n = 1;
        while (!req_ready) begin @(negedge clk); n++; end
        chk(n == CS_GAP, "R5 ready after gap", n, CS_GAP);

        // write while disabled: no change, but poll still completes
        run(3'd1, 3, 16'h1234, LONG, lat);
        chk(rsp_timeout == 0, "R7 poll ready", rsp_timeout, 0);
        read_chk(3, 16'h0F03, "R2 write ignored while disabled");

        run(3'd3, 0, 16'h0, SHORT, lat);
        chk(lat == SHORT * PER + CS_GAP + 1, "R10 enable latency", lat, SHORT * PER + CS_GAP + 1);

        for (int a = 0; a < 64; a++) begin
            run(3'd1, a, pat(a), LONG, lat);
            chk(rsp_timeout == 0 && lat >= LONG * PER + BUSY, "R7 write waits for ready",
                lat, LONG * PER + BUSY);
        end
        for (int a = 0; a < 64; a++) read_chk(a, pat(a), "R1 write/read data");

        run(3'd2, 17, 16'h0, SHORT, lat);
        chk(rsp_timeout == 0 && lat >= SHORT * PER + BUSY, "R7 erase polled", lat, SHORT * PER + BUSY);
        read_chk(17, 16'hFFFF, "R2 erase word");
        read_chk(18, pat(18), "R2 erase neighbour kept");

        run(3'd5, 0, 16'hC3A5, LONG, lat);
        chk(rsp_timeout == 0, "R7 fill polled", rsp_timeout, 0);
        read_chk(0, 16'hC3A5, "R2 write all low");
        read_chk(63, 16'hC3A5, "R2 write all high");
        read_chk(31, 16'hC3A5, "R2 write all mid");

        run(3'd6, 0, 16'h0, SHORT, lat);
        read_chk(0, 16'hFFFF, "R2 erase all");
        read_chk(40, 16'hFFFF, "R2 erase all");

        run(3'd4, 0, 16'h0, SHORT, lat);
        chk(lat == SHORT * PER + CS_GAP + 1, "R10 disable latency", lat, SHORT * PER + CS_GAP + 1);
        run(3'd1, 5, 16'h0001, LONG, lat);
        read_chk(5, 16'hFFFF, "R2 disable blocks write");

        run(3'd7, 0, 16'h0, SHORT, lat);
        run(3'd1, 6, 16'h0002, LONG, lat);
        read_chk(6, 16'hFFFF, "R2 code 7 acts as disable");

        // timeout
        run(3'd3, 0, 16'h0, SHORT, lat);
        stuck = 1;
        run(3'd2, 9, 16'h0, SHORT, lat);
        chk(rsp_timeout == 1, "R8 timeout flag", rsp_timeout, 1);
        chk(lat == SHORT * PER + 2 * CS_GAP + POLL_MAX + 1, "R8 timeout latency",
            lat, SHORT * PER + 2 * CS_GAP + POLL_MAX + 1);
        @(negedge clk);
        chk(req_ready == 1 && rsp_done == 0, "R9 single done, back to idle", rsp_done, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule